// File: doc/BRIEF.md
# Fault Event Classifier with Write-Locked Configuration

This block takes single-cycle fault event pulses from several detectors and sorts each one into a severe or an informational class. Event source 0 is the overvoltage detector on the secondary negative supply rail; the other sources behave the same way. A per-source mode bit in a second configuration register picks the class. Either way, a sticky error bit is recorded for the source in a secondary status register, and that bit is mirrored into a primary status register.

A severe event drives the active-low fault output low, raises an output turn-off request and moves the operating mode to a fault state. This fault state holds until a clear command arrives. An informational event leaves the mode, the turn-off request and the fault output alone.

The second configuration register is guarded. A write to it lands only while the unlock bit, bit 0 of the first configuration register, is set. The first configuration register can always be written.

Top module: `evt_classifier`

## Requirements
- R1: After reset, both configuration registers and both status registers read zero, `fault_n_o` is 1, `off_req_o` is 0 and `op_mode_o` is 2'b01 (run).
- R2: An event on source i while `cfg2_o[i]` is 0 is severe. On the next cycle `fault_n_o` is 0, `off_req_o` is 1 and `op_mode_o` is 2'b10 (fault).
- R3: An event on source i while `cfg2_o[i]` is 1 is informational. It does not change `fault_n_o`, `off_req_o` or `op_mode_o`.
- R4: An event on source i of either class sets `sec_err_o[i]` on the next cycle. `pri_err_o` always equals `sec_err_o`.
- R5: Error bits are sticky. They stay set through any number of cycles in which no clear write selects them.
- R6: A clear write (`err_clr_wr` high) clears, in both status registers, exactly the bits set in `err_clr_mask`. It leaves every other bit unchanged.
- R7: An event on source i in the same cycle as a clear write that selects bit i leaves that bit set.
- R8: The fault state holds until `fault_clr` is high. The cycle after that, the mode is run again, unless a severe event came in the same cycle as the clear, in which case the fault state remains.
- R9: A write to the second configuration register takes effect on the next cycle only if bit 0 of `cfg1_o` was 1 in the write cycle. A same-cycle write to the first register does not count. Otherwise the write is ignored.
- R10: A write to the first configuration register always takes effect on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_i | input | NUM_EVT | Event pulses, one per source; source 0 is negative-rail overvoltage |
| cfg1_wr | input | 1 | Write strobe, first configuration register |
| cfg1_din | input | CFG1_W | Write data, first configuration register (bit 0 = unlock) |
| cfg2_wr | input | 1 | Write strobe, second configuration register |
| cfg2_din | input | NUM_EVT | Write data, second configuration register (bit i = source i informational) |
| err_clr_wr | input | 1 | Write-one-to-clear strobe for the status registers |
| err_clr_mask | input | NUM_EVT | Bits to clear |
| fault_clr | input | 1 | Clear command for the fault operating mode |
| cfg1_o | output | CFG1_W | First configuration register |
| cfg2_o | output | NUM_EVT | Second configuration register |
| sec_err_o | output | NUM_EVT | Secondary status register, sticky error bits |
| pri_err_o | output | NUM_EVT | Primary status register, mirror of the error bits |
| fault_n_o | output | 1 | Fault output, active low |
| off_req_o | output | 1 | Output stage turn-off request |
| op_mode_o | output | 2 | Operating mode: 2'b01 run, 2'b10 fault |

## Verification
The bench builds the block with NUM_EVT = 4 and CFG1_W = 4. Four sources are enough to mix severe and informational events in one cycle and to aim clear masks at some set bits while sparing others. A four-bit first register also lets writes that toggle the unlock bit be told apart from writes that change only the other bits. Directed phases cover the following cases:
- locked writes to the second register;
- unlocking and locking again in the same cycle as a write;
- a clear that collides with an event;
- a fault clear that collides with a severe event.

A long pseudo-random phase then drives all inputs together.

// File: rtl/evt_classifier.sv
module evt_classifier #(
  parameter int NUM_EVT = 4,
  parameter int CFG1_W  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic               cfg1_wr,
  input  logic [CFG1_W-1:0]  cfg1_din,
  input  logic               cfg2_wr,
  input  logic [NUM_EVT-1:0] cfg2_din,
  input  logic               err_clr_wr,
  input  logic [NUM_EVT-1:0] err_clr_mask,
  input  logic               fault_clr,
  output logic [CFG1_W-1:0]  cfg1_o,
  output logic [NUM_EVT-1:0] cfg2_o,
  output logic [NUM_EVT-1:0] sec_err_o,
  output logic [NUM_EVT-1:0] pri_err_o,
  output logic               fault_n_o,
  output logic               off_req_o,
  output logic [1:0]         op_mode_o
);
  localparam int UNLOCK_BIT = 0;
  localparam logic [1:0] MODE_RUN   = 2'b01;
  localparam logic [1:0] MODE_FAULT = 2'b10;

  logic [CFG1_W-1:0]  cfg1_q;
  logic [NUM_EVT-1:0] cfg2_q, sec_q, pri_q, clr_sel, severe;
  logic [1:0]         mode_q;

  assign clr_sel = err_clr_wr ? err_clr_mask : '0;
  assign severe  = evt_i & ~cfg2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg1_q <= '0;
      cfg2_q <= '0;
    end else begin
      if (cfg1_wr) cfg1_q <= cfg1_din;
      if (cfg2_wr && cfg1_q[UNLOCK_BIT]) cfg2_q <= cfg2_din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q <= '0;
      pri_q <= '0;
    end else begin
      sec_q <= (sec_q & ~clr_sel) | evt_i;
      pri_q <= (pri_q & ~clr_sel) | evt_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          mode_q <= MODE_RUN;
    else if (|severe)    mode_q <= MODE_FAULT;
    else if (fault_clr)  mode_q <= MODE_RUN;
  end

  assign cfg1_o    = cfg1_q;
  assign cfg2_o    = cfg2_q;
  assign sec_err_o = sec_q;
  assign pri_err_o = pri_q;
  assign op_mode_o = mode_q;
  assign fault_n_o = (mode_q != MODE_FAULT);
  assign off_req_o = (mode_q == MODE_FAULT);
endmodule

module evt_classifier_chk #(
  parameter int NUM_EVT = 4,
  parameter int CFG1_W  = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_EVT-1:0] evt_i,
  input logic               cfg2_wr,
  input logic               err_clr_wr,
  input logic               fault_clr,
  input logic [CFG1_W-1:0]  cfg1_o,
  input logic [NUM_EVT-1:0] cfg2_o,
  input logic [NUM_EVT-1:0] sec_err_o,
  input logic [NUM_EVT-1:0] pri_err_o,
  input logic               fault_n_o,
  input logic               off_req_o,
  input logic [1:0]         op_mode_o
);
  assert_severe_faults_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_i & ~cfg2_o) != '0) |=> (!fault_n_o && off_req_o && op_mode_o == 2'b10));

  assert_info_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i != '0 && (evt_i & ~cfg2_o) == '0 && !fault_clr) |=>
      ($stable(fault_n_o) && $stable(off_req_o) && $stable(op_mode_o)));

  assert_evt_records_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i != '0) |=> ((sec_err_o & $past(evt_i)) == $past(evt_i)));

  assert_mirror_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pri_err_o == sec_err_o);

  assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !err_clr_wr |=> ((sec_err_o & $past(sec_err_o)) == $past(sec_err_o)));

  assert_fault_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_mode_o == 2'b10 && !fault_clr) |=> (op_mode_o == 2'b10));

  assert_locked_cfg2_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg2_wr && !cfg1_o[0]) |=> $stable(cfg2_o));

  assert_pins_agree_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (off_req_o == !fault_n_o) && $onehot0(op_mode_o));
endmodule

bind evt_classifier evt_classifier_chk #(.NUM_EVT(NUM_EVT), .CFG1_W(CFG1_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .cfg2_wr(cfg2_wr),
  .err_clr_wr(err_clr_wr), .fault_clr(fault_clr), .cfg1_o(cfg1_o),
  .cfg2_o(cfg2_o), .sec_err_o(sec_err_o), .pri_err_o(pri_err_o),
  .fault_n_o(fault_n_o), .off_req_o(off_req_o), .op_mode_o(op_mode_o)
);

// File: tb/sim_evt_classifier.sv
`timescale 1ns/1ps
module sim_evt_classifier;
  localparam int NE = 4;
  localparam int CW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NE-1:0] evt_i = '0;
  logic cfg1_wr = 1'b0;
  logic [CW-1:0] cfg1_din = '0;
  logic cfg2_wr = 1'b0;
  logic [NE-1:0] cfg2_din = '0;
  logic err_clr_wr = 1'b0;
  logic [NE-1:0] err_clr_mask = '0;
  logic fault_clr = 1'b0;
  logic [CW-1:0] cfg1_o;
  logic [NE-1:0] cfg2_o, sec_err_o, pri_err_o;
  logic fault_n_o, off_req_o;
  logic [1:0] op_mode_o;

  always #4 clk = ~clk;

  evt_classifier #(.NUM_EVT(NE), .CFG1_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .cfg1_wr(cfg1_wr), .cfg1_din(cfg1_din),
    .cfg2_wr(cfg2_wr), .cfg2_din(cfg2_din), .err_clr_wr(err_clr_wr),
    .err_clr_mask(err_clr_mask), .fault_clr(fault_clr), .cfg1_o(cfg1_o),
    .cfg2_o(cfg2_o), .sec_err_o(sec_err_o), .pri_err_o(pri_err_o),
    .fault_n_o(fault_n_o), .off_req_o(off_req_o), .op_mode_o(op_mode_o)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;
  bit done = 1'b0;

  int m_cfg1 = 0, m_cfg2 = 0, m_err = 0;
  bit m_fault = 1'b0;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (!rst_n) begin
      m_cfg1 <= 0; m_cfg2 <= 0; m_err <= 0; m_fault <= 1'b0;
    end else begin
      int e, keep;
      e = int'(evt_i);
      if (cfg1_wr) m_cfg1 <= int'(cfg1_din);
      if (cfg2_wr && (m_cfg1 % 2 == 1)) m_cfg2 <= int'(cfg2_din);
      keep = m_err;
      if (err_clr_wr) keep = keep & ~int'(err_clr_mask);
      m_err <= keep | e;
      if ((e & ~m_cfg2 & ((1 << NE) - 1)) != 0) m_fault <= 1'b1;
      else if (fault_clr) m_fault <= 1'b0;
    end
  end

  task automatic cmp(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual %0h expected %0h at cycle %0d", req, what, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      cmp("R10", "cfg1", int'(cfg1_o), m_cfg1);
      cmp("R9", "cfg2", int'(cfg2_o), m_cfg2);
      cmp("R4/R5/R6/R7", "sec_err", int'(sec_err_o), m_err);
      cmp("R4/R6", "pri_err", int'(pri_err_o), m_err);
      cmp("R2/R3", "fault_n", int'(fault_n_o), m_fault ? 0 : 1);
      cmp("R2/R3", "off_req", int'(off_req_o), m_fault ? 1 : 0);
      cmp("R8", "op_mode", int'(op_mode_o), m_fault ? 2 : 1);
    end
  end

  task automatic cyc(input logic [NE-1:0] e, input logic c1w, input logic [CW-1:0] c1d,
                     input logic c2w, input logic [NE-1:0] c2d, input logic cw,
                     input logic [NE-1:0] cm, input logic fc);
    @(negedge clk);
    #1;
    evt_i = e; cfg1_wr = c1w; cfg1_din = c1d; cfg2_wr = c2w; cfg2_din = c2d;
    err_clr_wr = cw; err_clr_mask = cm; fault_clr = fc;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc('0, 0, '0, 0, '0, 0, '0, 0);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired, actual running expected finished");
    finish_run();
  end

  initial begin
    logic [15:0] lfsr;
    lfsr = 16'hACE1;
    repeat (3) @(posedge clk);
    // R1: reset values
    @(negedge clk);
    cmp("R1", "reset cfg1", int'(cfg1_o), 0);
    cmp("R1", "reset sec_err", int'(sec_err_o), 0);
    cmp("R1", "reset op_mode", int'(op_mode_o), 1);
    cmp("R1", "reset fault_n", int'(fault_n_o), 1);
    rst_n = 1'b1;
    idle(2);
    // R9: locked write ignored
    cyc('0, 0, '0, 1, 4'b1111, 0, '0, 0);
    idle(1);
    cmp("R9", "locked cfg2", int'(cfg2_o), 0);
    // R10 unlock, R9 write while unlocked, with relock in same cycle
    cyc('0, 1, 4'b0001, 0, '0, 0, '0, 0);
    cyc('0, 1, 4'b0110, 1, 4'b0101, 0, '0, 0);
    idle(1);
    cmp("R9", "cfg2 unlocked", int'(cfg2_o), 5);
    cyc('0, 0, '0, 1, 4'b0011, 0, '0, 0);
    idle(1);
    cmp("R9", "cfg2 relocked", int'(cfg2_o), 5);
    // R3: informational events on sources 0 and 2
    cyc(4'b0101, 0, '0, 0, '0, 0, '0, 0);
    idle(2);
    cmp("R3", "info fault_n", int'(fault_n_o), 1);
    cmp("R4", "info sec_err", int'(sec_err_o), 5);
    // R6 partial clear, R7 clear colliding with event on bit 0
    cyc(4'b0001, 0, '0, 0, '0, 1, 4'b0101, 0);
    idle(1);
    cmp("R7", "collide keep", int'(sec_err_o), 1);
    // R2 severe on source 1, R5 sticky
    cyc(4'b0010, 0, '0, 0, '0, 0, '0, 0);
    idle(5);
    cmp("R2", "severe op_mode", int'(op_mode_o), 2);
    cmp("R5", "sticky", int'(sec_err_o), 3);
    // R8 clear colliding with severe keeps fault, then plain clear
    cyc(4'b1000, 0, '0, 0, '0, 0, '0, 1);
    idle(1);
    cmp("R8", "clear vs severe", int'(op_mode_o), 2);
    cyc('0, 0, '0, 0, '0, 0, '0, 1);
    idle(1);
    cmp("R8", "cleared", int'(op_mode_o), 1);
    cyc('0, 0, '0, 0, '0, 1, 4'b1111, 0);
    idle(1);
    cmp("R6", "full clear", int'(pri_err_o), 0);
    // random mix
    for (int k = 0; k < 3000; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cyc((lfsr[3:0] & {4{lfsr[15:14] == 2'b00}}), lfsr[4] & lfsr[5], lfsr[11:8],
          lfsr[6], lfsr[13:10], lfsr[7] & lfsr[2], lfsr[12:9], lfsr[8] & lfsr[1]);
    end
    idle(2);
    finish_run();
  end
endmodule